// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

The controller sits between a clocked host and an external asynchronous static RAM of 256K words by 8 bits. The RAM has active-low chip, output and write strobes. The host offers one request at a time on a valid/ready port: an 18-bit address, a byte of write data and a direction flag. Reads come back on a response port as a one-cycle valid pulse with the captured byte. Writes return nothing. The host may issue the next request once ready rises again.

All waits are counted in clock cycles. Two parameters set these counts: the clock period and the access time, which is also the cycle time. A third parameter sets the write-strobe width. Each count is the time divided by the clock period, rounded up, with a floor of one cycle.

The data bus is split at the pads into an output word, an output-enable and an input word. The controller turns its drivers on only while the RAM's output enable is high. Every write opens with a setup cycle in which all outputs are off. Data and address stay unchanged until after the write strobe rises.

Top module: `sram_ctrl`

## Requirements
- R1: During and straight after reset, all three strobes are high, the data drivers are off, rsp_valid_o is low and req_ready_o is high.
- R2: Whenever req_ready_o is high (idle), chip enable is high and the data drivers are off.
- R3: A read accepted at clock edge N keeps chip enable low, output enable low and write enable high for ACC_CYC = ceil(T_ACC_PS / CLK_PERIOD_PS) cycles. The bus is sampled at edge N+ACC_CYC, and rsp_valid_o is high for exactly the one cycle after that edge.
- R4: A write accepted at edge N runs as follows. First, one setup cycle with chip enable low, write enable high and drivers off. Next, WE_CYC = ceil(T_WP_PS / CLK_PERIOD_PS) cycles with write enable low and data driven. Last, one hold cycle with write enable high and data still driven. req_ready_o returns after edge N+WE_CYC+2.
- R5: While chip enable stays low, the address does not change. While the drivers stay on, the driven data does not change. At the rising edge of write enable, chip enable is still low and the drivers are still on.
- R6: The drivers are never on while the RAM drives the bus (chip enable low, output enable low, write enable high).
- R7: Output enable is high whenever write enable is low. The drivers turn on only after output enable has been high for at least one full cycle.
- R8: A request is accepted only on an edge where req_valid_i and req_ready_o are both high. req_ready_o stays low until the access ends. A request held valid through a busy period is carried out once.
- R9: A read returns the byte last written to that address, across the full address range and the data values 00, FF and mixed patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_rdata_o | output | 8 | Read data |
| sram_addr_o | output | 18 | RAM address |
| sram_ce_no | output | 1 | RAM chip enable, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_we_no | output | 1 | RAM write enable, active low |
| sram_dq_o | output | 8 | Data driven toward the RAM |
| sram_dq_oe_o | output | 1 | Enable for the data drivers |
| sram_dq_i | input | 8 | Data read from the RAM pads |

## Verification
The acceptance edge of each request is recorded as an edge count. With the default parameters, a read response is due exactly ACC_CYC (2) edges later, and a write frees the port exactly WE_CYC+2 (4) edges later. A scoreboard holds each expected byte together with its due edge. The monitor compares only on negative clock edges: it fails a response that comes at the wrong edge, one that never comes, or one that is not expected. The RAM model supplies garbage until the output has been enabled for ACC_CYC half-period-aligned samples, so a capture one edge early reads the wrong byte. The model stores data on the rising write strobe. On every negative edge the model also checks for contention and for the strobe rules.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } state_e;

  // time in ps -> cycles, rounded up, never below one
  function automatic int unsigned cyc_ceil(int unsigned t_ps, int unsigned p_ps);
    int unsigned c;
    c = (t_ps + p_ps - 1) / p_ps;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ACC_CYC = 2,
  parameter int unsigned WE_CYC  = 2,
  parameter int unsigned CW      = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          ready_o,
  output logic          accept_o,
  output logic          cap_o,
  output logic          ce_n_o,
  output logic          oe_n_o,
  output logic          we_n_o,
  output logic          dq_oe_o
);

  localparam logic [CW-1:0] ACC_LD = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] WE_LD  = CW'(WE_CYC - 1);

  state_e state_q, state_d;
  logic   ce_n_q, oe_n_q, we_n_q, dq_oe_q;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;
  assign cap_o    = (state_q == ST_RD) && tmr_zero_i;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (req_we_i) begin
            state_d = ST_WR_SETUP;
          end else begin
            state_d    = ST_RD;
            tmr_load_o = 1'b1;
            tmr_val_o  = ACC_LD;
          end
        end
      end
      ST_RD:       if (tmr_zero_i) state_d = ST_IDLE;
      ST_WR_SETUP: begin
        // bus stays undriven here: doubles as turnaround after a read
        state_d    = ST_WR_PULSE;
        tmr_load_o = 1'b1;
        tmr_val_o  = WE_LD;
      end
      ST_WR_PULSE: if (tmr_zero_i) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= (state_d == ST_IDLE);
      oe_n_q  <= (state_d != ST_RD);
      we_n_q  <= (state_d != ST_WR_PULSE);
      dq_oe_q <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
    end
  end

  assign ce_n_o  = ce_n_q;
  assign oe_n_o  = oe_n_q;
  assign we_n_o  = we_n_q;
  assign dq_oe_o = dq_oe_q;

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q <= addr_i;
      if (we_i) wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= cap_i;
      if (cap_i) rdata_q <= dq_i;
    end
  end

  assign addr_o      = addr_q;
  assign dq_o        = wdata_q;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned T_ACC_PS      = 10000,
  parameter int unsigned T_WP_PS       = 8000,
  parameter int unsigned AW            = 18,
  parameter int unsigned DW            = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce_no,
  output logic          sram_oe_no,
  output logic          sram_we_no,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);

  localparam int unsigned ACC_CYC = cyc_ceil(T_ACC_PS, CLK_PERIOD_PS);
  localparam int unsigned WE_CYC  = cyc_ceil(T_WP_PS, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC = (ACC_CYC > WE_CYC) ? ACC_CYC : WE_CYC;
  localparam int unsigned CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic          tmr_load, tmr_zero, accept, cap;
  logic [CW-1:0] tmr_val;

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sram_ctrl_fsm #(.ACC_CYC(ACC_CYC), .WE_CYC(WE_CYC), .CW(CW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .cap_o       (cap),
    .ce_n_o      (sram_ce_no),
    .oe_n_o      (sram_oe_no),
    .we_n_o      (sram_we_no),
    .dq_oe_o     (sram_dq_oe_o)
  );

  sram_ctrl_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .we_i        (req_we_i),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .cap_i       (cap),
    .dq_i        (sram_dq_i),
    .addr_o      (sram_addr_o),
    .dq_o        (sram_dq_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic [AW-1:0] sram_addr_o,
  input logic          sram_ce_no,
  input logic          sram_oe_no,
  input logic          sram_we_no,
  input logic [DW-1:0] sram_dq_o,
  input logic          sram_dq_oe_o
);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_ce_no && !sram_dq_oe_o));

  a_r3_rsp_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r5_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && !$past(sram_ce_no)) |-> $stable(sram_addr_o));

  a_r5_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));

  a_r5_we_rise_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (sram_dq_oe_o && !sram_ce_no));

  a_r6_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_dq_oe_o && !sram_ce_no && !sram_oe_no && sram_we_no));

  a_r7_oe_off_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_oe_no);

  a_r7_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (sram_oe_no && $past(sram_oe_no)));

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_ce_no   (sram_ce_no),
  .sram_oe_no   (sram_oe_no),
  .sram_we_no   (sram_we_no),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;

  localparam int ACC_CYC = 2;  // ceil(10000/5000)
  localparam int WE_CYC  = 2;  // ceil(8000/5000)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [17:0] sram_addr;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = 8'hEE;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sram_addr_o(sram_addr), .sram_ce_no(ce_n), .sram_oe_no(oe_n),
    .sram_we_no(we_n), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe),
    .sram_dq_i(dq_i)
  );

  function automatic logic [7:0] init_val(logic [17:0] a);
    return a[7:0] ^ {a[17:16], 6'b0} ^ 8'h3C;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // RAM model
  logic [7:0] ram [int];
  logic [7:0] shadow [int];
  int         rd_cnt = 0;
  logic [17:0] prev_addr = '0;

  function automatic logic [7:0] ram_rd(logic [17:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : init_val(a);
  endfunction

  always @(posedge we_n) begin
    if (rst_n && !ce_n) begin
      chk(dq_oe == 1'b1, "R5 drive at we rise", dq_oe, 1);
      ram[int'(sram_addr)] = dq_o;
    end
  end

  int we_low = 0;
  always @(negedge clk) begin
    bit rd_cond;
    rd_cond = !ce_n && !oe_n && we_n;
    if (rd_cond && rd_cnt > 0 && sram_addr == prev_addr) rd_cnt++;
    else rd_cnt = rd_cond ? 1 : 0;
    prev_addr = sram_addr;
    dq_i = !rd_cond ? 8'hEE : (rd_cnt >= ACC_CYC ? ram_rd(sram_addr) : ~ram_rd(sram_addr));
    if (rst_n) begin
      chk(!(dq_oe && rd_cond), "R6 contention", dq_oe, 0);
      if (req_ready) chk(ce_n && !dq_oe, "R2 idle quiet", {ce_n, dq_oe}, 2'b10);
      if (!we_n) begin
        chk(oe_n == 1'b1, "R7 oe high in write", oe_n, 1);
        we_low++;
      end else if (we_low != 0) begin
        chk(we_low == WE_CYC, "R4 we pulse width", we_low, WE_CYC);
        we_low = 0;
      end
    end
  end

  // scoreboard
  typedef struct { logic [7:0] data; int due; } exp_t;
  exp_t q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (q.size() == 0) chk(0, "R8 unexpected response", rsp_rdata, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.due, "R3 response edge", cyc, e.due);
          chk(rsp_rdata == e.data, "R9 read data", rsp_rdata, e.data);
        end
      end else if (q.size() != 0 && cyc > q[0].due) begin
        chk(0, "R3 response missing", cyc, q[0].due);
        void'(q.pop_front());
      end
    end
  end

  task automatic issue(bit we, logic [17:0] a, logic [7:0] d, bit early = 0);
    int acc;
    @(negedge clk);
    if (early) begin
      req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    end
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    #0.1 acc = cyc;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R8 busy after accept", req_ready, 0);
    if (we) begin
      shadow[int'(a)] = d;
      chk(!ce_n && we_n && oe_n && !dq_oe, "R4 setup cycle",
          {ce_n, we_n, oe_n, dq_oe}, 4'b0110);
      while (!req_ready && cyc < acc + WE_CYC + 10) begin
        if (!dq_oe || !ce_n) chk(dq_o == d && sram_addr == a, "R5 write hold",
                                   {sram_addr, dq_o}, {a, d});
        @(negedge clk);
      end
      chk(cyc == acc + WE_CYC + 2, "R4 write length", cyc, acc + WE_CYC + 2);
    end else begin
      exp_t e;
      e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
      e.due  = acc + ACC_CYC;
      q.push_back(e);
      chk(!ce_n && !oe_n && we_n && sram_addr == a, "R3 read strobes",
          {ce_n, oe_n, we_n}, 3'b001);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ce_n && oe_n && we_n && !dq_oe && !rsp_valid && req_ready, "R1 reset outputs",
        {ce_n, oe_n, we_n, dq_oe, rsp_valid, req_ready}, 6'b111001);
    rst_n = 1;
    @(negedge clk);
    chk(ce_n && oe_n && we_n && !dq_oe && req_ready, "R1 after reset",
        {ce_n, oe_n, we_n, dq_oe, req_ready}, 5'b11101);

    issue(0, 18'h00000, 0);
    issue(0, 18'h3FFFF, 0);
    issue(1, 18'h00005, 8'h00);
    issue(1, 18'h3FFFF, 8'hFF);
    issue(1, 18'h00000, 8'hA5);
    issue(0, 18'h00005, 0);
    issue(0, 18'h3FFFF, 0);
    issue(0, 18'h00000, 0);
    // write then read, read then write (turnaround)
    issue(1, 18'h01234, 8'h5A);
    issue(0, 18'h01234, 0);
    issue(1, 18'h01234, 8'hC3);
    issue(0, 18'h01234, 0);
    // R8: valid held through busy periods
    issue(1, 18'h2AAAA, 8'h96, 1);
    issue(0, 18'h2AAAA, 0, 1);
    issue(0, 18'h15555, 0, 1);
    for (int i = 0; i < 24; i++) begin
      logic [17:0] a;
      a = 18'(i * 7919 + 13) & 18'h3FFFF;
      issue(1, a, 8'(i * 37 + 1));
      issue(0, a, 0, i[0]);
      issue(0, 18'(a ^ 18'h20001), 0);
    end
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R3 all responses", q.size(), 0);
    finish_run();
  end

endmodule